// File: doc/BRIEF.md
# Interval Timer Countdown Channel

This block is one 16-bit countdown channel of a classic interval timer, reached over a small byte-wide register bus. Software writes a control word to pick how the count is loaded, writes the initial count one or two bytes at a time, and then waits for the channel output to go high. The count advances on a count-clock enable pulse (nominally 1193180 Hz, given as a package constant), so a delay in microseconds is converted into ticks as `us * TICK_HZ / 1_000_000`.

Only the interrupt-on-terminal-count behaviour with binary counting is built. The output is low while a count runs and goes high when the count reaches zero. A count-latch command freezes a copy of the count so that it can be read back as two bytes. A separate bit-mapped status/control register holds the gate and the speaker enable, and shows the live output. Control words aimed at other channels, at the read-back function, at other counting modes or at BCD counting are accepted on the bus and change nothing.

Top module: `pit_channel`

## Requirements
- R1: A control word whose bits 7:6 are not `10` has no effect on the count, the output or the load sequence.
- R2: A control word with bits 7:6 = `10`, bits 5:4 not `00`, bits 3:1 = `000` and bit 0 = `0` drives the output low, clears the low/high byte toggle and stops counting until a new count is fully loaded; bits 5:4 then set the load mode (`01` low byte only, `10` high byte only, `11` low byte then high byte).
- R3: A control word for this channel with bits 3:1 not `000` or bit 0 = `1` (and bits 5:4 not `00`) is ignored.
- R4: In low-then-high mode the first data write is the low byte and the second the high byte; counting starts only after the high byte.
- R5: In low-only mode a data write loads `{8'h00, byte}`; in high-only mode it loads `{byte, 8'h00}`; either starts counting at once.
- R6: While armed, the count drops by one on each clock cycle where the count enable is high and the gate bit is 1; with the gate at 0 it holds.
- R7: The output rises on the enable that takes the count from 1 to 0 and stays high while the count wraps, until a new control word or count byte is written.
- R8: A control word with bits 7:6 = `10` and bits 5:4 = `00` snapshots the count; the next two data reads return its low then high byte, after which the snapshot is released; a second latch while one is pending is ignored.
- R9: Status register (address 2) bit 0 is the gate and bit 1 the speaker enable, both writable; bit 5 is the live output and ignores writes; all other bits read 0.
- R10: An initial count of 0 acts as 65536: the first enabled step gives `16'hFFFF` and the output stays low.
- R11: With no snapshot pending, a data read returns the live count: the low byte in low-only mode, the high byte in high-only mode, and low then high alternately in low-then-high mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-clock enable, one cycle per count tick |
| bus_addr | input | 2 | Register select: 0 data port, 1 control word, 2 status/control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the data-port read sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| tmr_out | output | 1 | Channel output |
| spk_out | output | 1 | Channel output gated by the speaker enable |

## Verification
Every bus write takes effect at the clock edge that ends its cycle, so the output, the count and the status bits are sampled one time unit after that edge. Read data is combinational and is sampled inside the read cycle before its edge, so it shows the state left by earlier cycles. The output rises at the very edge of the enable cycle that reaches zero, which is why the bench checks it after exactly N-1 enables (still low) and after N (high). The random phase keeps a per-cycle model of count, gate and output and compares the output after each edge.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int unsigned TICK_HZ = 1193180;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    localparam logic [1:0] SEL_THIS    = 2'b10;
    localparam logic [2:0] MODE_TC_IRQ = 3'b000;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam int STAT_GATE_BIT = 0;
    localparam int STAT_SPK_BIT  = 1;
    localparam int STAT_OUT_BIT  = 5;
endpackage

// File: rtl/pit_ctrl_decode.sv
`timescale 1ns/1ps
module pit_ctrl_decode
    import pit_pkg::*;
(
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] cw,
    output logic              latch_cmd,
    output logic              mode_cmd,
    output acc_e              acc_new
);
    logic       hit;
    logic [1:0] sel;
    logic [2:0] mode;
    logic       bcd;

    always_comb begin
        sel     = cw[7:6];
        acc_new = acc_e'(cw[5:4]);
        mode    = cw[3:1];
        bcd     = cw[0];
        hit     = ctrl_wr && (sel == SEL_THIS);
        // R8: latch command targets this channel with access code 00
        latch_cmd = hit && (acc_new == ACC_LATCH);
        // R2/R3: only binary terminal-count mode is acted on
        mode_cmd  = hit && (acc_new != ACC_LATCH) && (mode == MODE_TC_IRQ) && !bcd;
    end
endmodule

// File: rtl/pit_load_seq.sv
`timescale 1ns/1ps
module pit_load_seq
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cmd,
    input  acc_e              acc_new,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output acc_e              acc,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              hold_stb
);
    typedef struct packed {
        acc_e              acc;
        logic              cfg;
        logic              wtog;
        logic [BYTE_W-1:0] lo;
    } ls_t;

    ls_t q, d;

    always_comb begin
        d        = q;
        load_stb = 1'b0;
        hold_stb = 1'b0;
        load_val = '0;
        if (mode_cmd) begin
            d.acc  = acc_new;
            d.cfg  = 1'b1;
            d.wtog = 1'b0;
        end else if (data_wr && q.cfg) begin
            case (q.acc)
                ACC_LO: begin
                    load_stb = 1'b1;
                    load_val = {{BYTE_W{1'b0}}, wbyte};
                end
                ACC_HI: begin
                    load_stb = 1'b1;
                    load_val = {wbyte, {BYTE_W{1'b0}}};
                end
                ACC_LOHI: begin
                    if (!q.wtog) begin
                        d.lo     = wbyte;
                        d.wtog   = 1'b1;
                        hold_stb = 1'b1;
                    end else begin
                        load_stb = 1'b1;
                        load_val = {wbyte, q.lo};
                        d.wtog   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.acc  <= ACC_LOHI;
            q.cfg  <= 1'b0;
            q.wtog <= 1'b0;
            q.lo   <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc = q.acc;

    // R4: a data byte in low-then-high mode flips the byte toggle
    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && q.cfg && !mode_cmd && q.acc == ACC_LOHI) |=> (q.wtog != $past(q.wtog)));

    // R2: a mode control word leaves the toggle cleared
    a_r2_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cmd |=> !q.wtog);
endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             stop,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             armed;
    } ctr_t;

    ctr_t q, d;

    always_comb begin
        d = q;
        if (stop) begin
            d.armed = 1'b0;
            d.out   = 1'b0;
        end else if (load_stb) begin
            d.cnt   = load_val;
            d.armed = 1'b1;
            d.out   = 1'b0;
        end else if (q.armed && gate && tick) begin
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.out = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt   <= '0;
            q.out   <= 1'b0;
            q.armed <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cnt = q.cnt;
    assign out = q.out;

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.armed && gate && tick && !stop && !load_stb) |=> (q.cnt == $past(q.cnt) - CNT_W'(1)));

    a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !load_stb) |=> $stable(q.cnt));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out && !stop && !load_stb) |=> q.out);

    a_r7_rise_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.out) |-> ($past(q.cnt) == CNT_W'(1)));

    a_r2_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!q.out && !q.armed));
endmodule

// File: rtl/pit_latch_rd.sv
`timescale 1ns/1ps
module pit_latch_rd
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_cmd,
    input  logic              mode_cmd,
    input  logic              data_rd,
    input  acc_e              acc,
    input  logic [CNT_W-1:0]  cnt,
    output logic [BYTE_W-1:0] rbyte
);
    typedef struct packed {
        logic [CNT_W-1:0] snap;
        logic             held;
        logic             rhi;
        logic             rtog;
    } lr_t;

    lr_t q, d;

    always_comb begin
        if (q.held) begin
            rbyte = q.rhi ? q.snap[CNT_W-1:BYTE_W] : q.snap[BYTE_W-1:0];
        end else begin
            case (acc)
                ACC_HI:   rbyte = cnt[CNT_W-1:BYTE_W];
                ACC_LOHI: rbyte = q.rtog ? cnt[CNT_W-1:BYTE_W] : cnt[BYTE_W-1:0];
                default:  rbyte = cnt[BYTE_W-1:0];
            endcase
        end

        d = q;
        if (mode_cmd) begin
            d.rtog = 1'b0;
        end
        if (data_rd) begin
            if (q.held) begin
                if (q.rhi) begin
                    d.held = 1'b0;
                    d.rhi  = 1'b0;
                end else begin
                    d.rhi = 1'b1;
                end
            end else if (acc == ACC_LOHI) begin
                d.rtog = ~q.rtog;
            end
        end
        if (latch_cmd && !q.held) begin
            d.snap = cnt;
            d.held = 1'b1;
            d.rhi  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.snap <= '0;
            q.held <= 1'b0;
            q.rhi  <= 1'b0;
            q.rtog <= 1'b0;
        end else begin
            q <= d;
        end
    end

    a_r8_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.held && !(data_rd && q.rhi)) |=> (q.held && $stable(q.snap)));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.held && q.rhi && data_rd && !latch_cmd) |=> !q.held);

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_cmd && !q.held) |=> (q.held && q.snap == $past(cnt)));
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              tmr_out,
    output logic              spk_out
);
    typedef struct packed {
        logic gate;
        logic spk;
    } st_t;

    st_t st_q, st_d;

    logic              ctrl_wr, data_wr, stat_wr, data_rd;
    logic              latch_cmd, mode_cmd, load_stb, hold_stb;
    acc_e              acc_new, acc;
    logic [CNT_W-1:0]  load_val, cnt;
    logic [BYTE_W-1:0] rbyte, stat_byte;
    logic              out;

    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == REG_CTRL);
        data_wr = bus_wr && (bus_addr == REG_DATA);
        stat_wr = bus_wr && (bus_addr == REG_STAT);
        data_rd = bus_rd && (bus_addr == REG_DATA);
    end

    pit_ctrl_decode u_dec (
        .ctrl_wr   (ctrl_wr),
        .cw        (bus_wdata),
        .latch_cmd (latch_cmd),
        .mode_cmd  (mode_cmd),
        .acc_new   (acc_new)
    );

    pit_load_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_cmd (mode_cmd),
        .acc_new  (acc_new),
        .data_wr  (data_wr),
        .wbyte    (bus_wdata),
        .acc      (acc),
        .load_stb (load_stb),
        .load_val (load_val),
        .hold_stb (hold_stb)
    );

    pit_counter u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .gate     (st_q.gate),
        .stop     (mode_cmd || hold_stb),
        .load_stb (load_stb),
        .load_val (load_val),
        .cnt      (cnt),
        .out      (out)
    );

    pit_latch_rd u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_cmd (latch_cmd),
        .mode_cmd  (mode_cmd),
        .data_rd   (data_rd),
        .acc       (acc),
        .cnt       (cnt),
        .rbyte     (rbyte)
    );

    always_comb begin
        st_d = st_q;
        if (stat_wr) begin
            st_d.gate = bus_wdata[STAT_GATE_BIT];
            st_d.spk  = bus_wdata[STAT_SPK_BIT];
        end
        stat_byte                = '0;
        stat_byte[STAT_GATE_BIT] = st_q.gate;
        stat_byte[STAT_SPK_BIT]  = st_q.spk;
        stat_byte[STAT_OUT_BIT]  = out;
        case (bus_addr)
            REG_DATA: bus_rdata = rbyte;
            REG_STAT: bus_rdata = stat_byte;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gate <= 1'b0;
            st_q.spk  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_out = out;
    assign spk_out = out && st_q.spk;

    a_r9_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (st_q.gate == $past(bus_wdata[STAT_GATE_BIT]) &&
                     st_q.spk  == $past(bus_wdata[STAT_SPK_BIT])));

    a_r9_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> $stable(st_q));

    a_r1_foreign_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7:6] != SEL_THIS) |-> (!mode_cmd && !latch_cmd));
endmodule

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
    import pit_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_out, spk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pit_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tmr_out(tmr_out), .spk_out(spk_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] a, input logic wr, input logic rd,
                       input logic [7:0] wd, input logic te, output logic [7:0] rb);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; tick_en = te;
        #1 rb = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] x;
        cyc(a, 1'b1, 1'b0, d, 1'b0, x);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        cyc(a, 1'b0, 1'b1, 8'h00, 1'b0, d);
    endtask

    task automatic ticks(input int n);
        logic [7:0] x;
        for (int i = 0; i < n; i++) cyc(REG_CTRL, 1'b0, 1'b0, 8'h00, 1'b1, x);
    endtask

    task automatic latch_read(output logic [15:0] v);
        logic [7:0] lo, hi;
        wr_reg(REG_CTRL, 8'h80);
        rd_reg(REG_DATA, lo);
        rd_reg(REG_DATA, hi);
        v = {hi, lo};
    endtask

    function automatic int unsigned us_to_ticks(input int unsigned us);
        return int'((64'(us) * 64'(TICK_HZ)) / 64'd1000000);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int unsigned n;
        logic [15:0] mcnt;
        logic        mout, mgate;
        int unsigned r;

        r = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        chk("R7 reset out", tmr_out, 1'b0);
        rd_reg(REG_STAT, b);
        chk("R9 reset status", b, 8'h00);

        // R9: bit 5 read-only, others zero
        wr_reg(REG_STAT, 8'hFF);
        rd_reg(REG_STAT, b);
        chk("R9 status write ff", b, 8'h03);
        wr_reg(REG_STAT, 8'h01);

        // R4 + R7: delay derived from tick rate
        n = us_to_ticks(20);
        chk("R4 tick conversion", n, 32'd23);
        wr_reg(REG_CTRL, 8'hB0);
        chk("R2 out low after cw", tmr_out, 1'b0);
        wr_reg(REG_DATA, n[7:0]);
        ticks(3);
        chk("R4 no start after low byte", tmr_out, 1'b0);
        wr_reg(REG_DATA, n[15:8]);
        latch_read(v);
        chk("R4 loaded count", v, 16'(n));
        ticks(int'(n) - 1);
        chk("R7 still low at N-1", tmr_out, 1'b0);
        ticks(1);
        chk("R7 high at N", tmr_out, 1'b1);
        rd_reg(REG_STAT, b);
        chk("R9 status shows out", b, 8'h21);
        ticks(5);
        chk("R7 sticky after wrap", tmr_out, 1'b1);
        latch_read(v);
        chk("R7 wrapped count", v, 16'hFFFB);

        // R1: other channels and read-back
        wr_reg(REG_CTRL, 8'h30);
        wr_reg(REG_CTRL, 8'hC2);
        chk("R1 out unchanged", tmr_out, 1'b1);
        ticks(2);
        latch_read(v);
        chk("R1 count continues", v, 16'hFFF9);

        // R3: other mode, BCD
        wr_reg(REG_CTRL, 8'hB4);
        wr_reg(REG_CTRL, 8'hB1);
        chk("R3 out unchanged", tmr_out, 1'b1);
        ticks(2);
        latch_read(v);
        chk("R3 count continues", v, 16'hFFF7);

        // R2: mode word stops counting, clears toggle
        wr_reg(REG_CTRL, 8'hB0);
        chk("R2 out low", tmr_out, 1'b0);
        ticks(4);
        latch_read(v);
        chk("R2 count frozen", v, 16'hFFF7);
        wr_reg(REG_DATA, 8'h11);
        wr_reg(REG_CTRL, 8'hB0);
        wr_reg(REG_DATA, 8'h05);
        wr_reg(REG_DATA, 8'h00);
        latch_read(v);
        chk("R2 toggle cleared", v, 16'h0005);

        // R6: gate
        wr_reg(REG_STAT, 8'h00);
        ticks(3);
        latch_read(v);
        chk("R6 gate low holds", v, 16'h0005);
        wr_reg(REG_STAT, 8'h01);
        ticks(2);
        latch_read(v);
        chk("R6 gate high counts", v, 16'h0003);

        // R8: second latch ignored, release after two reads
        wr_reg(REG_CTRL, 8'h80);
        ticks(2);
        wr_reg(REG_CTRL, 8'h80);
        rd_reg(REG_DATA, b);
        chk("R8 snapshot low", b, 8'h03);
        rd_reg(REG_DATA, b);
        chk("R8 snapshot high", b, 8'h00);
        rd_reg(REG_DATA, b);
        chk("R11 live low after release", b, 8'h01);
        rd_reg(REG_DATA, b);
        chk("R11 live high", b, 8'h00);

        // R5: low-only and high-only
        wr_reg(REG_CTRL, 8'h90);
        wr_reg(REG_DATA, 8'h07);
        latch_read(v);
        chk("R5 low-only load", v, 16'h0007);
        ticks(7);
        chk("R5 low-only expiry", tmr_out, 1'b1);
        wr_reg(REG_CTRL, 8'hA0);
        wr_reg(REG_DATA, 8'h02);
        chk("R5 out low after load", tmr_out, 1'b0);
        latch_read(v);
        chk("R5 high-only load", v, 16'h0200);
        rd_reg(REG_DATA, b);
        chk("R11 high-only live read", b, 8'h02);

        // R10: zero count
        wr_reg(REG_CTRL, 8'hB0);
        wr_reg(REG_DATA, 8'h00);
        wr_reg(REG_DATA, 8'h00);
        ticks(3);
        latch_read(v);
        chk("R10 zero acts as 65536", v, 16'hFFFD);
        chk("R10 out low", tmr_out, 1'b0);

        // random phase against a model (R6, R7)
        mgate = 1'b1;
        wr_reg(REG_STAT, 8'h01);
        for (int round = 0; round < 30; round++) begin
            mcnt = 16'(1 + ($urandom % 24));
            if ($urandom % 2 == 0) begin
                wr_reg(REG_CTRL, 8'h90);
                wr_reg(REG_DATA, mcnt[7:0]);
            end else begin
                wr_reg(REG_CTRL, 8'hB0);
                wr_reg(REG_DATA, mcnt[7:0]);
                wr_reg(REG_DATA, mcnt[15:8]);
            end
            mout = 1'b0;
            for (int s = 0; s < 60; s++) begin
                if ($urandom % 8 == 0) begin
                    mgate = ~mgate;
                    wr_reg(REG_STAT, {7'b0, mgate});
                end else begin
                    logic te;
                    logic [7:0] x;
                    te = 1'($urandom % 2);
                    cyc(REG_CTRL, 1'b0, 1'b0, 8'h00, te, x);
                    if (mgate && te) begin
                        if (mcnt == 16'd1) mout = 1'b1;
                        mcnt = mcnt - 16'd1;
                    end
                end
                chk("R7 random out", tmr_out, mout);
            end
            latch_read(v);
            chk("R6 random count", v, mcnt);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule